// File: doc/BRIEF.md
# Cache victim way selector

This block decides which way of a set-associative cache gets evicted when a line fill needs room. Software-visible configuration (policy, lock count, fallback way) arrives as plain inputs. The cache pipeline presents a fill request with its set index and the requesting master's index. One cycle later the block answers with a victim way, or with a flag saying that no way may be evicted.

Four policies are selectable at run time:
- a tree pseudo-LRU kept per set;
- a pseudo-random pick driven by a free-running LFSR;
- the master index used directly as a way, with a fallback way when the index is out of range;
- the master index reduced modulo the way count.

A lock count reserves the lowest-numbered ways. No policy may return them. Hit notifications and granted fills keep the recency trees current whatever policy is active. A change of policy therefore only alters the next answer, not the history.

Top module: `victim_way_sel`

## Requirements
- R1: A fill request in cycle t produces its answer in the outputs during cycle t+1 only. In any cycle after one with no request, `victim_valid_o` and `no_victim_o` are 0 and `victim_way_o` is 0.
- R2: With policy 2'b00 the victim is found by walking the set's tree. The tree has N-1 bits, with node k having children 2k+1 and 2k+2. A bit of 0 steers left, toward lower ways, and 1 steers right. Leaf index minus (N-1) is the way.
- R3: With policy 2'b01 the victim is L + (S mod (N-L)). Here L is the lock count and S is the 16-bit LFSR value in the request cycle. The LFSR is seeded 16'hACE1 at reset and shifts left every cycle. Its new bit 0 is S[15]^S[13]^S[12]^S[10].
- R4: With policy 2'b10 the raw way is the master index when it is below N. Otherwise the raw way is the fallback way input modulo N.
- R5: With policy 2'b11 the raw way is the master index modulo N.
- R6: A hit, and a fill that yields a victim, each update the addressed set's tree along the accessed way's path. Every node on that path is made to point away from the way. When both touch the same set in one cycle, the fill update is applied after the hit update. Updates happen under every policy.
- R7: Ways 0 to L-1 are locked. A raw way r below L from policy 2'b00, 2'b10 or 2'b11 is replaced by L + (r mod (N-L)).
- R8: When L >= N, a fill request yields `no_victim_o` = 1, `victim_valid_o` = 0 and way 0, and the request leaves the recency state untouched.
- R9: After reset all trees are zero, so the first LRU victim of any set is way 0. The outputs are 0.
- R10: The policy sampled with each request applies to that request alone. Alternating policies on consecutive requests gives each answer its own policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Replacement policy select |
| master_idx_i | input | MIDX_W (4) | Index of the master issuing the fill |
| fallback_way_i | input | FB_W (4) | Way used by policy 2'b10 when the master index is out of range |
| lock_cnt_i | input | LOCK_W (4) | Number of locked low ways |
| hit_valid_i | input | 1 | Cache hit notification |
| hit_set_i | input | SET_W (4) | Set index of the hit |
| hit_way_i | input | WAY_W (2) | Way that hit |
| fill_req_i | input | 1 | Request for a victim |
| fill_set_i | input | SET_W (4) | Set index of the fill |
| victim_valid_o | output | 1 | Victim way valid |
| victim_way_o | output | WAY_W (2) | Selected victim way |
| no_victim_o | output | 1 | All ways locked, no victim available |

## Verification
The hardest case to reach from the ports is a pseudo-LRU tree that points into the locked range while a lock count is active. Reaching it needs a particular history of hits and fills on one set before the lock is raised. To get there, the stimulus confines traffic to four sets, mixes hits with fills, and changes the lock count and policy on every cycle. This makes collisions between a hit and a fill on the same set frequent. Directed sequences first walk a fresh tree through all four ways. They then alternate policies on back-to-back requests.

// File: rtl/vws_pkg.sv
package vws_pkg;
  typedef enum logic [1:0] {
    POL_PLRU = 2'b00,
    POL_RAND = 2'b01,
    POL_MIDX = 2'b10,
    POL_MMOD = 2'b11
  } policy_e;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/vws_lfsr.sv
module vws_lfsr
  import vws_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] state_q;
  logic              fb;

  assign fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LFSR_SEED;
    else         state_q <= {state_q[LFSR_W-2:0], fb};
  end

  assign state_o = state_q;

  a_r3_lfsr_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/vws_plru_store.sv
module vws_plru_store #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned WAY_W = $clog2(NUM_WAYS),
  localparam int unsigned SET_W = $clog2(NUM_SETS),
  localparam int unsigned NODES = NUM_WAYS - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] rd_set_i,
  output logic [WAY_W-1:0] rd_way_o,
  input  logic             a_en_i,
  input  logic [SET_W-1:0] a_set_i,
  input  logic [WAY_W-1:0] a_way_i,
  input  logic             b_en_i,
  input  logic [SET_W-1:0] b_set_i,
  input  logic [WAY_W-1:0] b_way_i
);
  logic [NUM_SETS-1:0][NODES-1:0] tree_q, tree_d;

  // point every node on the way's path away from it
  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t_in,
                                             input logic [WAY_W-1:0] w);
    logic [NODES-1:0] t;
    int node;
    t = t_in;
    node = 0;
    for (int l = 0; l < int'(WAY_W); l++) begin
      t[node] = ~w[WAY_W-1-l];
      node = 2 * node + 1 + int'(w[WAY_W-1-l]);
    end
    return t;
  endfunction

  function automatic logic [WAY_W-1:0] walk(input logic [NODES-1:0] t);
    int node;
    node = 0;
    for (int l = 0; l < int'(WAY_W); l++) node = 2 * node + 1 + int'(t[node]);
    return WAY_W'(node - int'(NODES));
  endfunction

  for (genvar s = 0; s < int'(NUM_SETS); s++) begin : g_set
    logic [NODES-1:0] after_a;
    assign after_a   = (a_en_i && a_set_i == SET_W'(s)) ? touch(tree_q[s], a_way_i) : tree_q[s];
    assign tree_d[s] = (b_en_i && b_set_i == SET_W'(s)) ? touch(after_a, b_way_i) : after_a;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tree_q <= '0;
    else         tree_q <= tree_d;
  end

  assign rd_way_o = walk(tree_q[rd_set_i]);

  // root must steer away from the half holding the filled way
  a_r6_root_away: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_en_i |=> tree_q[$past(b_set_i)][0] == ~$past(b_way_i[WAY_W-1]));
endmodule

// File: rtl/vws_pick.sv
module vws_pick
  import vws_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned MIDX_W   = 4,
  parameter int unsigned FB_W     = 4,
  parameter int unsigned LOCK_W   = 4,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [1:0]        policy_i,
  input  logic [WAY_W-1:0]  plru_way_i,
  input  logic [LFSR_W-1:0] lfsr_i,
  input  logic [MIDX_W-1:0] master_idx_i,
  input  logic [FB_W-1:0]   fallback_i,
  input  logic [LOCK_W-1:0] lock_cnt_i,
  output logic [WAY_W-1:0]  way_o,
  output logic              none_o
);
  int lock_n, unl, raw, pick;

  always_comb begin
    lock_n = int'(lock_cnt_i);
    unl    = int'(NUM_WAYS) - lock_n;
    none_o = lock_n >= int'(NUM_WAYS);
    raw    = 0;
    pick   = 0;
    unique case (policy_e'(policy_i))
      POL_PLRU: raw = int'(plru_way_i);
      POL_RAND: raw = 0;
      POL_MIDX: raw = (int'(master_idx_i) < int'(NUM_WAYS)) ? int'(master_idx_i)
                                                           : int'(fallback_i) % int'(NUM_WAYS);
      POL_MMOD: raw = int'(master_idx_i) % int'(NUM_WAYS);
      default:  raw = 0;
    endcase
    if (none_o)                            pick = 0;
    else if (policy_e'(policy_i) == POL_RAND) pick = lock_n + int'(lfsr_i) % unl;
    else if (raw < lock_n)                 pick = lock_n + raw % unl;
    else                                   pick = raw;
    way_o = WAY_W'(pick);
  end
endmodule

// File: rtl/victim_way_sel.sv
module victim_way_sel
  import vws_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned MIDX_W   = 4,
  parameter int unsigned FB_W     = 4,
  parameter int unsigned LOCK_W   = 4,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
  localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        policy_i,
  input  logic [MIDX_W-1:0] master_idx_i,
  input  logic [FB_W-1:0]   fallback_way_i,
  input  logic [LOCK_W-1:0] lock_cnt_i,
  input  logic              hit_valid_i,
  input  logic [SET_W-1:0]  hit_set_i,
  input  logic [WAY_W-1:0]  hit_way_i,
  input  logic              fill_req_i,
  input  logic [SET_W-1:0]  fill_set_i,
  output logic              victim_valid_o,
  output logic [WAY_W-1:0]  victim_way_o,
  output logic              no_victim_o
);
  localparam logic [LOCK_W-1:0] WAYS_L = LOCK_W'(NUM_WAYS);
  localparam logic [MIDX_W-1:0] WAYS_M = MIDX_W'(NUM_WAYS);

  logic [LFSR_W-1:0] lfsr;
  logic [WAY_W-1:0]  plru_way, pick_way;
  logic              pick_none, grant;

  vws_lfsr u_lfsr (.clk_i, .rst_ni, .state_o(lfsr));

  vws_plru_store #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_plru (
    .clk_i, .rst_ni,
    .rd_set_i(fill_set_i), .rd_way_o(plru_way),
    .a_en_i(hit_valid_i), .a_set_i(hit_set_i), .a_way_i(hit_way_i),
    .b_en_i(grant), .b_set_i(fill_set_i), .b_way_i(pick_way)
  );

  vws_pick #(.NUM_WAYS(NUM_WAYS), .MIDX_W(MIDX_W), .FB_W(FB_W), .LOCK_W(LOCK_W)) u_pick (
    .policy_i, .plru_way_i(plru_way), .lfsr_i(lfsr), .master_idx_i,
    .fallback_i(fallback_way_i), .lock_cnt_i, .way_o(pick_way), .none_o(pick_none)
  );

  assign grant = fill_req_i && !pick_none;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_valid_o <= 1'b0;
      victim_way_o   <= '0;
      no_victim_o    <= 1'b0;
    end else begin
      victim_valid_o <= grant;
      victim_way_o   <= grant ? pick_way : '0;
      no_victim_o    <= fill_req_i && pick_none;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_req_i |=> !victim_valid_o && !no_victim_o && victim_way_o == '0);
  a_r1_one_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_i |=> victim_valid_o ^ no_victim_o);
  a_r7_skip_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_i && lock_cnt_i < WAYS_L |=> LOCK_W'(victim_way_o) >= $past(lock_cnt_i));
  a_r8_all_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_i && lock_cnt_i >= WAYS_L |=> no_victim_o && !victim_valid_o);
  a_r5_modulo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_i && policy_i == 2'b11 && lock_cnt_i == '0
    |=> victim_way_o == $past(master_idx_i[WAY_W-1:0]));
  a_r4_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_i && policy_i == 2'b10 && lock_cnt_i == '0 && master_idx_i < WAYS_M
    |=> victim_way_o == $past(master_idx_i[WAY_W-1:0]));
endmodule

// File: tb/tb_victim_way_sel.sv
`timescale 1ns/1ps
module tb_victim_way_sel;
  localparam int N = 4;
  localparam int SETS = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] policy_i = '0;
  logic [3:0] master_idx_i = '0, fallback_way_i = '0, lock_cnt_i = '0;
  logic       hit_valid_i = 1'b0, fill_req_i = 1'b0;
  logic [3:0] hit_set_i = '0, fill_set_i = '0;
  logic [1:0] hit_way_i = '0;
  logic       victim_valid_o, no_victim_o;
  logic [1:0] victim_way_o;

  always #4 clk_i = ~clk_i;

  victim_way_sel dut (.*);

  int checks = 0, fails = 0;
  bit done = 0, run_chk = 0;

  // reference model
  int tr[SETS][N-1];
  logic [15:0] m_lfsr;
  int e_v, e_nv, e_w;
  string e_tag;

  function automatic int ref_walk(int s);
    int node = 0;
    for (int l = 0; l < 2; l++) node = 2 * node + 1 + tr[s][node];
    return node - (N - 1);
  endfunction

  function automatic void ref_touch(int s, int w);
    int node = 0;
    for (int l = 1; l >= 0; l--) begin
      int d = (w >> l) & 1;
      tr[s][node] = 1 - d;
      node = 2 * node + 1 + d;
    end
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (tr[s, k]) tr[s][k] = 0;
      m_lfsr = 16'hACE1;
      e_v = 0; e_nv = 0; e_w = 0; e_tag = "R9";
    end else begin
      int lk, u, r, p;
      e_v = 0; e_nv = 0; e_w = 0; e_tag = "R1";
      if (fill_req_i) begin
        lk = lock_cnt_i;
        p  = policy_i;
        if (lk >= N) begin
          e_nv = 1; e_tag = "R8";
        end else begin
          u = N - lk;
          case (p)
            0: begin r = ref_walk(fill_set_i); e_tag = "R2/R6"; end
            1: begin r = lk + (m_lfsr % u); e_tag = "R3"; end
            2: begin r = (master_idx_i < N) ? master_idx_i : fallback_way_i % N; e_tag = "R4"; end
            default: begin r = master_idx_i % N; e_tag = "R5"; end
          endcase
          if (p != 1 && r < lk) begin r = lk + (r % u); e_tag = "R7"; end
          e_v = 1; e_w = r;
        end
      end
      if (hit_valid_i) ref_touch(hit_set_i, hit_way_i);
      if (e_v) ref_touch(fill_set_i, e_w);
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
  end

  task automatic check(string tag, int av, int anv, int aw, int xv, int xnv, int xw);
    checks++;
    if (av != xv || anv != xnv || aw != xw) begin
      fails++;
      $display("FAIL %s: got valid=%0d none=%0d way=%0d, expected valid=%0d none=%0d way=%0d",
               tag, av, anv, aw, xv, xnv, xw);
    end
  endtask

  always @(negedge clk_i)
    if (run_chk) check(e_tag, victim_valid_o, no_victim_o, victim_way_o, e_v, e_nv, e_w);

  task automatic drive(int pol, int lk, int fset, bit fill, bit hit, int hset, int hway,
                       int midx, int fb);
    @(negedge clk_i);
    policy_i = 2'(pol); lock_cnt_i = 4'(lk); fill_set_i = 4'(fset); fill_req_i = fill;
    hit_valid_i = hit; hit_set_i = 4'(hset); hit_way_i = 2'(hway);
    master_idx_i = 4'(midx); fallback_way_i = 4'(fb);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9", victim_valid_o, no_victim_o, victim_way_o, 0, 0, 0); // R9 reset state
    run_chk = 1;
    // R2/R6: fresh tree yields 0,2,1,3
    for (int i = 0; i < 5; i++) drive(0, 0, 3, 1, 0, 0, 0, 0, 0);
    // R6: hit steers next victim, hit and fill same set
    drive(0, 0, 5, 1, 1, 5, 0, 0, 0);
    drive(0, 0, 5, 1, 1, 5, 3, 0, 0);
    // R4: out-of-range index uses fallback; R5 modulo
    drive(2, 0, 0, 1, 0, 0, 0, 9, 6);
    drive(2, 0, 0, 1, 0, 0, 0, 2, 6);
    drive(3, 0, 0, 1, 0, 0, 0, 13, 0);
    // R7 remap and R8 all locked (no state change on set 3)
    drive(3, 2, 0, 1, 0, 0, 0, 1, 0);
    drive(0, 4, 3, 1, 0, 0, 0, 0, 0);
    drive(0, 0, 3, 1, 0, 0, 0, 0, 0);
    // R10: policy alternates on back-to-back requests; R3 random
    for (int i = 0; i < 8; i++) drive(i % 4, 1, 2, 1, 0, 0, 0, i + 3, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0); // R1 idle
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom % 10;
      drive($urandom % 4, (r < 5) ? 0 : (r < 9 ? $urandom % 4 : 4 + $urandom % 2),
            $urandom % 4, ($urandom % 10) < 6, $urandom % 2, $urandom % 4, $urandom % 4,
            $urandom % 16, $urandom % 16);
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk_i);
    run_chk = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule